// File: doc/BRIEF.md
# Low-Power DDR Power-Up Initialization Sequencer

This block sits on the controller side of a low-power DDR SDRAM interface. It takes the memory from power-up to a ready state. After reset it holds the clock enable high and puts only NOP on the command bus. It waits for a power-good indication and then lets a programmable settling window of clocked NOPs pass. After that it issues the one fixed set of commands the memory needs before normal use: one PRECHARGE ALL, two AUTO REFRESH commands, and one MODE REGISTER SET for each of the two mode registers. Each command is followed by its own programmable quiet gap.

Two configuration inputs adjust the order. One moves both refresh commands after the mode-register writes. The other writes the extended register before the base register. Both settings are captured together with the two mode-register values when the sequence starts. The done flag is raised only after the quiet gap that follows the final command. Nothing else may use the bus before then.

Top module: `lpddr_init_seq`

## Requirements
- R1: `cke` is high in every cycle after reset, including during reset, the settling window and after completion.
- R2: While `pwr_ok` stays low after reset, `cmd` is NOP (code 0) and `init_done` is low.
- R3: Once `pwr_ok` is seen high, at least `settle_cycles` NOP cycles pass before the first command. The first command is always PRECHARGE ALL (code 1). With it, address bit 10 is high, every other address bit is zero, and `bank` is zero.
- R4: After each command, exactly max(N,1) NOP cycles pass before the next command. N is `trp_cycles` after PRECHARGE ALL, `trfc_cycles` after AUTO REFRESH and `tmrd_cycles` after MODE REGISTER SET.
- R5: Exactly five commands are issued. With `refresh_late`=0 the order is PRECHARGE ALL, AUTO REFRESH (code 2), AUTO REFRESH, then two MODE REGISTER SET (code 3). With `refresh_late`=1 the order is PRECHARGE ALL, the two MODE REGISTER SET, then the two AUTO REFRESH.
- R6: A MODE REGISTER SET to the base register drives `bank`=2'b00 and `addr`=`base_mr`. A write to the extended register drives `bank`=2'b10 and `addr`=`ext_mr`. With `ext_first`=1 the extended write comes first; otherwise the base write comes first. An AUTO REFRESH drives `bank` and `addr` to zero.
- R7: `refresh_late`, `ext_first`, `base_mr` and `ext_mr` are captured in the cycle the sequence starts. Changing them later has no effect on the commands issued.
- R8: `init_done` rises after exactly max(N,1) NOP cycles following the fifth command. It then stays high, and `cmd` stays NOP.
- R9: A synchronous active-low reset at any point forces NOP, zero bank and address, and low `init_done`. The next `pwr_ok` then restarts the full sequence from PRECHARGE ALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supplies stable and clock running; starts the sequence |
| refresh_late | input | 1 | 1: refreshes after both mode-register writes |
| ext_first | input | 1 | 1: extended mode register written before base |
| settle_cycles | input | SETTLE_W (16) | NOP cycles in the settling window |
| trp_cycles | input | GAP_W (8) | Quiet gap after PRECHARGE ALL |
| trfc_cycles | input | GAP_W (8) | Quiet gap after each AUTO REFRESH |
| tmrd_cycles | input | GAP_W (8) | Quiet gap after each MODE REGISTER SET |
| base_mr | input | ADDR_W (13) | Value written to the base mode register |
| ext_mr | input | ADDR_W (13) | Value written to the extended mode register |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 2 | Command code: 0 NOP, 1 PRECHARGE ALL, 2 AUTO REFRESH, 3 MODE REGISTER SET |
| bank | output | BA_W (2) | Bank address; selects the mode register |
| addr | output | ADDR_W (13) | Address bus |
| init_done | output | 1 | Memory ready for normal commands |

## Verification
The bench goes after the gap boundaries. A zero gap must still leave one NOP, and a gap of one must leave exactly one. A counter that is off by one at either end would shift every later command and the done flag by a cycle. It changes the order and mode-register inputs in the middle of a sequence. A design that does not capture them would switch to the other order or write the wrong register value. It aborts a sequence with reset partway through. Any state that survives the reset would make the rerun skip PRECHARGE ALL or start from a later step. It also holds `pwr_ok` low for a while and then watches the bus long after completion, which exposes a stray command before the start or after done.

// File: rtl/lpddr_init_pkg.sv
// Shared types for the power-up initialization sequencer.
// Assumes exactly five initialization commands and a two-bit bank field.
package lpddr_init_pkg;

    // Command codes driven on the cmd port
    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_AREF = 2'd2,
        CMD_MRS  = 2'd3
    } bus_cmd_e;

    // Internal action chosen for one step of the sequence
    typedef enum logic [1:0] {
        ACT_PREA,
        ACT_AREF,
        ACT_MRS_BASE,
        ACT_MRS_EXT
    } init_act_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_ISSUE,
        PH_WAIT,
        PH_DONE
    } init_phase_e;

    localparam int unsigned NUM_STEPS = 5;
    localparam int unsigned STEP_W    = 3;

    // Maps a step index and the captured configuration to an action
    function automatic init_act_e step_action(
        input logic [STEP_W-1:0] step,
        input logic              late,
        input logic              ext_first
    );
        init_act_e mr_a;
        init_act_e mr_b;
        init_act_e act;
        mr_a = ext_first ? ACT_MRS_EXT  : ACT_MRS_BASE;
        mr_b = ext_first ? ACT_MRS_BASE : ACT_MRS_EXT;
        case (step)
            3'd0:    act = ACT_PREA;
            3'd1:    act = late ? mr_a : ACT_AREF;
            3'd2:    act = late ? mr_b : ACT_AREF;
            3'd3:    act = late ? ACT_AREF : mr_a;
            default: act = late ? ACT_AREF : mr_b;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/init_gap_timer.sv
// Down-counter that times the settling window and the gaps between commands.
// Assumes load and tick are never needed together; load wins if both are high.
// last is high while the count is 0 or 1, so a loaded value N gives max(N,1) cycles.
module init_gap_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Reload on every phase entry, otherwise count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick && count != '0) begin
            count <= count - ONE;
        end
    end

    // Final cycle of the current window
    assign last = (count <= ONE);

    // R4: the counter advances by exactly one per ticked cycle
    a_r4_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count > ONE) |=> (count == $past(count) - ONE));

    // R4: a reload takes the requested value
    a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

endmodule

// File: rtl/init_step_fsm.sv
// Phase and step control for the initialization sequence.
// Captures the order configuration when the sequence starts and chooses the
// action and gap length for each step. Assumes GAP_W <= SETTLE_W.
module init_step_fsm
    import lpddr_init_pkg::*;
#(
    parameter int unsigned SETTLE_W = 16,
    parameter int unsigned GAP_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_ok,
    input  logic                cfg_late,
    input  logic                cfg_ext_first,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [GAP_W-1:0]    trp_cycles,
    input  logic [GAP_W-1:0]    trfc_cycles,
    input  logic [GAP_W-1:0]    tmrd_cycles,
    input  logic                timer_last,
    output logic                timer_load,
    output logic [SETTLE_W-1:0] timer_val,
    output logic                timer_tick,
    output logic                start,
    output logic                issue,
    output init_act_e           issue_act,
    output logic                in_done
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    init_phase_e       phase;
    logic [STEP_W-1:0] step;
    logic              late_q;
    logic              extf_q;
    logic [GAP_W-1:0]  gap_sel;

    // Action of the current step under the captured configuration
    assign issue_act = step_action(step, late_q, extf_q);

    // Gap length that belongs to the current action
    always_comb begin
        unique case (issue_act)
            ACT_PREA: gap_sel = trp_cycles;
            ACT_AREF: gap_sel = trfc_cycles;
            default:  gap_sel = tmrd_cycles;
        endcase
    end

    // Timer control and issue strobe for the current phase
    always_comb begin
        timer_load = 1'b0;
        timer_val  = '0;
        timer_tick = 1'b0;
        start      = 1'b0;
        issue      = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (pwr_ok) begin
                    start      = 1'b1;
                    timer_load = 1'b1;
                    timer_val  = settle_cycles;
                end
            end
            PH_SETTLE: timer_tick = 1'b1;
            PH_ISSUE: begin
                issue      = 1'b1;
                timer_load = 1'b1;
                timer_val  = SETTLE_W'(gap_sel);
            end
            PH_WAIT: timer_tick = 1'b1;
            default: ;
        endcase
    end

    // Phase, step and captured configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            step   <= '0;
            late_q <= 1'b0;
            extf_q <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (pwr_ok) begin
                        late_q <= cfg_late;
                        extf_q <= cfg_ext_first;
                        step   <= '0;
                        phase  <= PH_SETTLE;
                    end
                end
                PH_SETTLE: begin
                    if (timer_last) begin
                        phase <= PH_ISSUE;
                    end
                end
                PH_ISSUE: phase <= PH_WAIT;
                PH_WAIT: begin
                    if (timer_last) begin
                        if (step == LAST_STEP) begin
                            phase <= PH_DONE;
                        end else begin
                            step  <= step + 1'b1;
                            phase <= PH_ISSUE;
                        end
                    end
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

    assign in_done = (phase == PH_DONE);

    // R2: no progress without power-good
    a_r2_wait_for_power: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !pwr_ok) |=> (phase == PH_IDLE));

    // R7: captured order settings do not move once the sequence runs
    a_r7_config_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> ($stable(late_q) && $stable(extf_q)));

    // R5: the step index never passes the fifth command
    a_r5_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST_STEP);

    // R8: completion is never left without reset
    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> (phase == PH_DONE));

endmodule

// File: rtl/init_bus_driver.sv
// Registers the memory command bus from the sequencer's issue strobe.
// Captures both mode-register values when the sequence starts.
// Assumes BA_W >= 2 and AP_BIT < ADDR_W.
module init_bus_driver
    import lpddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned BA_W   = 2,
    parameter int unsigned AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] ext_val,
    input  logic              issue,
    input  init_act_e         issue_act,
    input  logic              in_done,
    output logic              cke,
    output logic [1:0]        cmd,
    output logic [BA_W-1:0]   bank,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam logic [BA_W-1:0]   BA_BASE = BA_W'(0);
    localparam logic [BA_W-1:0]   BA_EXT  = BA_W'(2);
    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ext_q;

    // Clock enable is held high from reset onward
    assign cke = 1'b1;

    // Capture mode-register contents at sequence start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ext_q  <= '0;
        end else if (start) begin
            base_q <= base_val;
            ext_q  <= ext_val;
        end
    end

    // Drive one command cycle per issue strobe, NOP otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd  <= CMD_NOP;
            bank <= '0;
            addr <= '0;
            done <= 1'b0;
        end else begin
            cmd  <= CMD_NOP;
            bank <= '0;
            addr <= '0;
            done <= in_done;
            if (issue) begin
                unique case (issue_act)
                    ACT_PREA: begin
                        cmd  <= CMD_PREA;
                        addr <= AP_MASK;
                    end
                    ACT_AREF: cmd <= CMD_AREF;
                    ACT_MRS_BASE: begin
                        cmd  <= CMD_MRS;
                        bank <= BA_BASE;
                        addr <= base_q;
                    end
                    default: begin
                        cmd  <= CMD_MRS;
                        bank <= BA_EXT;
                        addr <= ext_q;
                    end
                endcase
            end
        end
    end

    // R4: every command is followed by at least one NOP
    a_r4_nop_after_command: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // R8: done stays high once raised
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8: bus is quiet once done
    a_r8_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd == CMD_NOP));

    // R6: mode-register writes select only the base or extended register
    a_r6_mrs_bank_select: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> (bank == BA_BASE || bank == BA_EXT));

    // R3: precharge-all carries the all-banks address bit
    a_r3_prea_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PREA) |-> (addr == AP_MASK && bank == '0));

endmodule

// File: rtl/lpddr_init_seq.sv
// Top of the power-up initialization sequencer: a step FSM, a shared gap
// timer and a registered command-bus driver. Assumes the clock is already
// stable when pwr_ok rises and that only reset restarts the sequence.
module lpddr_init_seq
    import lpddr_init_pkg::*;
#(
    parameter int unsigned SETTLE_W = 16,
    parameter int unsigned GAP_W    = 8,
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned BA_W     = 2,
    parameter int unsigned AP_BIT   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_ok,
    input  logic                refresh_late,
    input  logic                ext_first,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [GAP_W-1:0]    trp_cycles,
    input  logic [GAP_W-1:0]    trfc_cycles,
    input  logic [GAP_W-1:0]    tmrd_cycles,
    input  logic [ADDR_W-1:0]   base_mr,
    input  logic [ADDR_W-1:0]   ext_mr,
    output logic                cke,
    output logic [1:0]          cmd,
    output logic [BA_W-1:0]     bank,
    output logic [ADDR_W-1:0]   addr,
    output logic                init_done
);

    logic                timer_load;
    logic [SETTLE_W-1:0] timer_val;
    logic                timer_tick;
    logic                timer_last;
    logic [SETTLE_W-1:0] timer_count;
    logic                start;
    logic                issue;
    init_act_e           issue_act;
    logic                in_done;

    init_step_fsm #(
        .SETTLE_W (SETTLE_W),
        .GAP_W    (GAP_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_ok        (pwr_ok),
        .cfg_late      (refresh_late),
        .cfg_ext_first (ext_first),
        .settle_cycles (settle_cycles),
        .trp_cycles    (trp_cycles),
        .trfc_cycles   (trfc_cycles),
        .tmrd_cycles   (tmrd_cycles),
        .timer_last    (timer_last),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .timer_tick    (timer_tick),
        .start         (start),
        .issue         (issue),
        .issue_act     (issue_act),
        .in_done       (in_done)
    );

    init_gap_timer #(
        .CNT_W (SETTLE_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .tick     (timer_tick),
        .count    (timer_count),
        .last     (timer_last)
    );

    init_bus_driver #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .AP_BIT (AP_BIT)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_val  (base_mr),
        .ext_val   (ext_mr),
        .issue     (issue),
        .issue_act (issue_act),
        .in_done   (in_done),
        .cke       (cke),
        .cmd       (cmd),
        .bank      (bank),
        .addr      (addr),
        .done      (init_done)
    );

    // R9: outputs return to the idle values in the cycle after reset
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cmd == 2'd0 && init_done == 1'b0 && bank == '0 && addr == '0));

    // R7: the timer never counts while idle
    a_r7_idle_timer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_ok && !start && !timer_tick && !timer_load) |=> $stable(timer_count));

endmodule

// File: tb/sim_lpddr_init_seq.sv
module sim_lpddr_init_seq;

    localparam int SW = 16;
    localparam int GW = 8;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b0;
    logic          refresh_late = 1'b0;
    logic          ext_first = 1'b0;
    logic [SW-1:0] settle_cycles = '0;
    logic [GW-1:0] trp_cycles = '0;
    logic [GW-1:0] trfc_cycles = '0;
    logic [GW-1:0] tmrd_cycles = '0;
    logic [AW-1:0] base_mr = '0;
    logic [AW-1:0] ext_mr = '0;
    logic          cke;
    logic [1:0]    cmd;
    logic [1:0]    bank;
    logic [AW-1:0] addr;
    logic          init_done;

    always #2 clk = ~clk;

    lpddr_init_seq u0 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .refresh_late(refresh_late),
        .ext_first(ext_first), .settle_cycles(settle_cycles), .trp_cycles(trp_cycles),
        .trfc_cycles(trfc_cycles), .tmrd_cycles(tmrd_cycles), .base_mr(base_mr),
        .ext_mr(ext_mr), .cke(cke), .cmd(cmd), .bank(bank), .addr(addr),
        .init_done(init_done)
    );

    typedef struct {
        logic [1:0]    c;
        logic [1:0]    ba;
        logic [AW-1:0] a;
        int            gap;
        string         req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // monitor state
    bit mon_en = 0;
    int nop_cnt = 0;
    bit have_prev = 0;
    int prev_gap = 0;
    int settle_exp = 0;
    bit done_seen = 0;
    int cmd_seen = 0;
    int cke_bad = 0;
    int quiet_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int gmin1(input int n);
        return (n < 1) ? 1 : n;
    endfunction

    // Driver: push the expected command stream (R5, R6)
    task automatic push_expected(input bit late, input bit extf,
                                 input logic [AW-1:0] bv, input logic [AW-1:0] ev,
                                 input int trp, input int trfc, input int tmrd);
        exp_t pre, ref1, mra, mrb;
        pre  = '{2'd1, 2'd0, 13'h0400, gmin1(trp), "R3"};
        ref1 = '{2'd2, 2'd0, 13'h0000, gmin1(trfc), "R5"};
        if (extf) begin
            mra = '{2'd3, 2'd2, ev, gmin1(tmrd), "R6"};
            mrb = '{2'd3, 2'd0, bv, gmin1(tmrd), "R6"};
        end else begin
            mra = '{2'd3, 2'd0, bv, gmin1(tmrd), "R6"};
            mrb = '{2'd3, 2'd2, ev, gmin1(tmrd), "R6"};
        end
        q.delete();
        q.push_back(pre);
        if (late) begin
            q.push_back(mra); q.push_back(mrb); q.push_back(ref1); q.push_back(ref1);
        end else begin
            q.push_back(ref1); q.push_back(ref1); q.push_back(mra); q.push_back(mrb);
        end
    endtask

    // Monitor: pop and compare as commands appear
    always @(negedge clk) begin
        if (mon_en) begin
            if (cke !== 1'b1) cke_bad++;
            if (done_seen) begin
                if (cmd !== 2'd0 || init_done !== 1'b1) quiet_bad++;
            end else if (init_done === 1'b1) begin
                done_seen = 1;
                chk(nop_cnt == prev_gap, "R8", "nops before done", nop_cnt, prev_gap);
                chk(q.size() == 0, "R5", "commands left", q.size(), 0);
                chk(cmd == 2'd0, "R8", "cmd at done", cmd, 0);
            end else if (cmd == 2'd0) begin
                nop_cnt++;
            end else if (q.size() == 0) begin
                chk(0, "R5", "extra command", cmd, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (!have_prev)
                    chk(nop_cnt >= settle_exp, "R3", "settle nops", nop_cnt, settle_exp);
                else
                    chk(nop_cnt == prev_gap, "R4", "gap nops", nop_cnt, prev_gap);
                chk(cmd == e.c, e.req, "cmd code", cmd, e.c);
                chk(bank == e.ba, e.req, "bank", bank, e.ba);
                chk(addr == e.a, e.req, "addr", addr, e.a);
                prev_gap = e.gap;
                have_prev = 1;
                nop_cnt = 0;
                cmd_seen++;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        pwr_ok = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic setup(input int s, input int trp, input int trfc, input int tmrd,
                         input bit late, input bit extf,
                         input logic [AW-1:0] bv, input logic [AW-1:0] ev);
        settle_cycles = SW'(s);
        trp_cycles = GW'(trp);
        trfc_cycles = GW'(trfc);
        tmrd_cycles = GW'(tmrd);
        refresh_late = late;
        ext_first = extf;
        base_mr = bv;
        ext_mr = ev;
        push_expected(late, extf, bv, ev, trp, trfc, tmrd);
        settle_exp = s;
    endtask

    task automatic run_seq(input int tail);
        nop_cnt = 0; have_prev = 0; prev_gap = 0; done_seen = 0;
        cmd_seen = 0; cke_bad = 0; quiet_bad = 0;
        @(posedge clk); #1;
        mon_en = 1;
        pwr_ok = 1'b1;
        for (int i = 0; i < 20000 && !done_seen; i++) @(posedge clk);
        chk(done_seen, "R8", "done reached", done_seen, 1);
        repeat (tail) @(posedge clk);
        #1 mon_en = 0;
        chk(quiet_bad == 0, "R8", "bus activity after done", quiet_bad, 0);
        chk(cke_bad == 0, "R1", "cke low cycles", cke_bad, 0);
    endtask

    initial begin
        int bad;
        do_reset();
        // R9/R1: reset state
        @(negedge clk);
        chk(cmd == 2'd0, "R9", "reset cmd", cmd, 0);
        chk(init_done == 1'b0, "R9", "reset done", init_done, 0);
        chk(cke == 1'b1, "R1", "reset cke", cke, 1);
        chk(bank == 2'd0 && addr == '0, "R9", "reset bank/addr", {bank, addr}, 0);

        // R2: no power-good, nothing happens
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cmd !== 2'd0 || init_done !== 1'b0 || cke !== 1'b1) bad++;
        end
        chk(bad == 0, "R2", "activity without pwr_ok", bad, 0);

        // Early refresh, base first
        setup(20, 3, 7, 2, 1'b0, 1'b0, 13'h0033, 13'h0020);
        run_seq(30);

        // Late refresh, extended first, minimum gaps
        do_reset();
        setup(5, 0, 1, 5, 1'b1, 1'b1, 13'h1abc, 13'h0155);
        run_seq(10);

        // Zero settle window, late refresh, base first
        do_reset();
        setup(0, 2, 0, 1, 1'b1, 1'b0, 13'h0042, 13'h0003);
        run_seq(10);

        // R7: change configuration after the first command
        do_reset();
        setup(8, 2, 4, 3, 1'b0, 1'b0, 13'h0101, 13'h0202);
        fork
            run_seq(10);
            begin
                wait (cmd_seen >= 1);
                @(posedge clk); #1;
                refresh_late = 1'b1;
                ext_first = 1'b1;
                base_mr = 13'h1fff;
                ext_mr = 13'h0fff;
            end
        join

        // R9: reset partway through, then a full rerun
        do_reset();
        setup(4, 2, 3, 2, 1'b0, 1'b1, 13'h0011, 13'h0022);
        @(posedge clk); #1;
        pwr_ok = 1'b1;
        repeat (14) @(posedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        chk(cmd == 2'd0 && init_done == 1'b0, "R9", "mid-run reset outputs",
            {init_done, cmd}, 0);
        chk(bank == 2'd0 && addr == '0 && cke == 1'b1, "R9", "mid-run reset bus",
            {cke, bank, addr}, {1'b1, 15'd0});
        @(posedge clk); #1 rst_n = 1'b1;
        pwr_ok = 1'b0;
        setup(4, 2, 3, 2, 1'b0, 1'b1, 13'h0011, 13'h0022);
        run_seq(20);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule